// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This block is the purely combinational execution slice for the second byte of a two-byte prefixed instruction in a small 8-bit processor. It takes the prefixed opcode byte, an 8-bit operand already fetched by the surrounding datapath, and the current flag nibble. It returns the result byte, the new flag nibble, a write-back enable and the number of machine cycles the instruction occupies.

The opcode is split into three fields. The top two bits choose one of four groups: the shift group, bit test, bit clear and bit set. The middle three bits choose either the shift operation or the bit index. The low three bits name the operand source. The unit does not select registers or access memory. The only use it makes of the low field is to detect the memory operand code, which lengthens the instruction.

Flags travel as a 4-bit nibble: bit 3 zero (Z), bit 2 subtract (N), bit 1 half-carry (H), bit 0 carry (C).

Top module: `pbu_top`

## Requirements
- R1: Opcode bits 7:6 select the group: 0 = shift group, 1 = bit test, 2 = bit clear, 3 = bit set. Bits 5:3 give the shift operation or the bit index.
- R2: In the shift group, operation 0 rotates left with bit 7 wrapping into bit 0. Operation 1 rotates right with bit 0 wrapping into bit 7. In both, carry out (flags bit 0) receives the bit that wrapped.
- R3: In the shift group, operation 2 rotates left through carry: incoming carry goes to bit 0 and old bit 7 goes to carry. Operation 3 rotates right through carry: incoming carry goes to bit 7 and old bit 0 goes to carry.
- R4: In the shift group, operation 4 shifts left, fills bit 0 with 0 and moves old bit 7 to carry. Operation 5 shifts right, keeps bit 7 and moves old bit 0 to carry. Operation 7 shifts right, clears bit 7 and moves old bit 0 to carry.
- R5: In the shift group, operation 6 exchanges the two nibbles and clears carry.
- R6: Every shift-group operation clears N (bit 2) and H (bit 1), and sets Z (bit 3) exactly when the result is zero.
- R7: Bit test sets Z to the inverse of the selected operand bit, sets H, clears N and passes carry through. The result equals the operand, and write-back is off.
- R8: Bit clear and bit set force only the selected bit to 0 or 1, respectively. The flags are output unchanged.
- R9: The write-back enable is 1 for the shift, bit clear and bit set groups, and 0 for bit test.
- R10: The cycle count is 2, or 4 when opcode bits 2:0 equal 6 (the memory operand).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Prefixed opcode byte |
| opnd_i | input | 8 | Operand value |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_o | output | 8 | Result byte |
| flags_o | output | 4 | Outgoing flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result should be written back |
| mcyc_o | output | 3 | Machine cycles taken |

## Verification
The assertions check several properties whenever the inputs change:
- In the shift group, N and H are clear, Z tracks the result, and swap clears carry.
- Bit test never writes back, returns the operand unchanged and keeps carry.
- Bit clear and bit set touch at most one bit and pass the flags through.
- The cycle count is always 2 or 4.

The exact data movement of each rotate and shift, the carry source, and the index-to-bit mapping can only be shown by the bench. The bench sweeps every opcode against every operand, with both carry values and varying other flag bits, and compares every output against an arithmetic model.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL_C  = 3'd0,
    SH_ROR_C  = 3'd1,
    SH_ROL_T  = 3'd2,
    SH_ROR_T  = 3'd3,
    SH_SHL    = 3'd4,
    SH_SHR_A  = 3'd5,
    SH_SWAP   = 3'd6,
    SH_SHR_L  = 3'd7
  } sh_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/pbu_shift.sv
module pbu_shift
  import pbu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  sh_e               sel_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  always_comb begin
    res_o   = opnd_i;
    carry_o = 1'b0;
    unique case (sel_i)
      SH_ROL_C: begin
        res_o   = {opnd_i[MSB-1:0], opnd_i[MSB]};
        carry_o = opnd_i[MSB];
      end
      SH_ROR_C: begin
        res_o   = {opnd_i[0], opnd_i[MSB:1]};
        carry_o = opnd_i[0];
      end
      SH_ROL_T: begin
        res_o   = {opnd_i[MSB-1:0], carry_i};
        carry_o = opnd_i[MSB];
      end
      SH_ROR_T: begin
        res_o   = {carry_i, opnd_i[MSB:1]};
        carry_o = opnd_i[0];
      end
      SH_SHL: begin
        res_o   = {opnd_i[MSB-1:0], 1'b0};
        carry_o = opnd_i[MSB];
      end
      SH_SHR_A: begin
        res_o   = {opnd_i[MSB], opnd_i[MSB:1]};
        carry_o = opnd_i[0];
      end
      SH_SWAP: begin
        res_o   = {opnd_i[HALF-1:0], opnd_i[MSB:HALF]};
        carry_o = 1'b0;
      end
      SH_SHR_L: begin
        res_o   = {1'b0, opnd_i[MSB:1]};
        carry_o = opnd_i[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (sel_i == SH_SWAP) p_swap_no_carry_r5: assert (!carry_o);
  end
endmodule

// File: rtl/pbu_bit.sv
module pbu_bit
  import pbu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  grp_e              grp_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (idx_i == IDX_W'(i));
  end

  assign bit_o = |(opnd_i & mask);

  always_comb begin
    unique case (grp_i)
      GRP_CLR: res_o = opnd_i & ~mask;
      GRP_SET: res_o = opnd_i | mask;
      default: res_o = opnd_i;
    endcase
  end

  always_comb begin
    p_mask_onehot_r8: assert ($onehot0(mask));
    if (grp_i == GRP_CLR || grp_i == GRP_SET)
      p_one_bit_r8: assert ($countones(res_o ^ opnd_i) <= 1);
  end
endmodule

// File: rtl/pbu_cycles.sv
module pbu_cycles #(
  parameter int SRC_W    = 3,
  parameter int MEM_CODE = 6,
  parameter int BASE_CYC = 2,
  parameter int MEM_CYC  = 2,
  parameter int CYC_W    = 3
) (
  input  logic [SRC_W-1:0] src_i,
  output logic [CYC_W-1:0] mcyc_o
);
  logic is_mem;

  assign is_mem = (src_i == SRC_W'(MEM_CODE));
  assign mcyc_o = is_mem ? CYC_W'(BASE_CYC + MEM_CYC) : CYC_W'(BASE_CYC);

  always_comb begin
    p_cyc_range_r10: assert (mcyc_o == CYC_W'(BASE_CYC) || mcyc_o == CYC_W'(BASE_CYC + MEM_CYC));
  end
endmodule

// File: rtl/pbu_top.sv
module pbu_top
  import pbu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CYC_W    = 3,
  parameter int BASE_CYC = 2,
  parameter int MEM_CYC  = 2,
  parameter int MEM_CODE = 6
) (
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        flags_o,
  output logic              wr_en_o,
  output logic [CYC_W-1:0]  mcyc_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int SRC_W = 3;

  grp_e              grp;
  sh_e               sh_sel;
  logic [IDX_W-1:0]  idx;
  logic [SRC_W-1:0]  src;
  flags_t            f_in, f_out;
  logic [DATA_W-1:0] sh_res, bit_res;
  logic              sh_carry, sel_bit;

  // R1: field split
  assign grp    = grp_e'(op_i[7:6]);
  assign sh_sel = sh_e'(op_i[5:3]);
  assign idx    = IDX_W'(op_i[5:3]);
  assign src    = op_i[2:0];
  assign f_in   = flags_t'(flags_i);

  pbu_shift #(.DATA_W(DATA_W)) u_shift (
    .sel_i   (sh_sel),
    .opnd_i  (opnd_i),
    .carry_i (f_in.c),
    .res_o   (sh_res),
    .carry_o (sh_carry)
  );

  pbu_bit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
    .grp_i  (grp),
    .idx_i  (idx),
    .opnd_i (opnd_i),
    .res_o  (bit_res),
    .bit_o  (sel_bit)
  );

  pbu_cycles #(
    .SRC_W(SRC_W), .MEM_CODE(MEM_CODE), .BASE_CYC(BASE_CYC),
    .MEM_CYC(MEM_CYC), .CYC_W(CYC_W)
  ) u_cyc (
    .src_i  (src),
    .mcyc_o (mcyc_o)
  );

  always_comb begin
    f_out = f_in;
    res_o = bit_res;
    unique case (grp)
      GRP_SHIFT: begin
        res_o   = sh_res;
        f_out.z = (sh_res == '0);
        f_out.n = 1'b0;
        f_out.h = 1'b0;
        f_out.c = sh_carry;
      end
      GRP_TEST: begin
        res_o   = opnd_i;
        f_out.z = ~sel_bit;
        f_out.n = 1'b0;
        f_out.h = 1'b1;
      end
      default: ;
    endcase
  end

  assign flags_o = f_out;
  assign wr_en_o = (grp != GRP_TEST);

  always_comb begin
    if (grp == GRP_SHIFT)
      p_shift_flags_r6: assert (flags_o[2:1] == 2'b00 && flags_o[3] == (res_o == '0));
    if (grp == GRP_TEST)
      p_test_no_wb_r7: assert (!wr_en_o && res_o == opnd_i && flags_o[0] == flags_i[0] && flags_o[1]);
    if (grp == GRP_CLR || grp == GRP_SET)
      p_flags_kept_r8: assert (flags_o == flags_i);
    p_wb_groups_r9: assert (wr_en_o == (op_i[7:6] != 2'b01));
  end
endmodule

// File: tb/sim_pbu_top.sv
module sim_pbu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op, opnd, res;
  logic [3:0] fl_in, fl_out;
  logic       wr_en;
  logic [2:0] mcyc;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pbu_top u0 (
    .op_i(op), .opnd_i(opnd), .flags_i(fl_in),
    .res_o(res), .flags_o(fl_out), .wr_en_o(wr_en), .mcyc_o(mcyc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s op=%02h opnd=%02h fl=%h actual=%0h expected=%0h", tag, op, opnd, fl_in, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] o, input logic [7:0] v, input logic [3:0] f,
                       output logic [7:0] r, output logic [3:0] fo, output logic w,
                       output logic [2:0] cy);
    logic [1:0] x = o[7:6];
    logic [2:0] y = o[5:3];
    logic c = f[0];
    logic nc = 1'b0;
    r = v;
    fo = f;
    w = (x != 2'd1);
    cy = (o[2:0] == 3'd6) ? 3'd4 : 3'd2;
    case (x)
      2'd0: begin
        case (y)
          3'd0: begin r = (v << 1) | (v >> 7); nc = v[7]; end
          3'd1: begin r = (v >> 1) | (v << 7); nc = v[0]; end
          3'd2: begin r = (v << 1) | {7'd0, c}; nc = v[7]; end
          3'd3: begin r = (v >> 1) | {c, 7'd0}; nc = v[0]; end
          3'd4: begin r = v << 1; nc = v[7]; end
          3'd5: begin r = (v >> 1) | (v & 8'h80); nc = v[0]; end
          3'd6: begin r = {v[3:0], v[7:4]}; nc = 1'b0; end
          default: begin r = v >> 1; nc = v[0]; end
        endcase
        fo = {(r == 8'd0), 1'b0, 1'b0, nc};
      end
      2'd1: fo = {~v[y], 1'b0, 1'b1, c};
      2'd2: r = v & ~(8'd1 << y);
      default: r = v | (8'd1 << y);
    endcase
  endtask

  function automatic string res_tag(input logic [7:0] o);
    if (o[7:6] != 2'd0) return (o[7:6] == 2'd1) ? "R1,R7" : "R1,R8";
    case (o[5:3])
      3'd0, 3'd1: return "R1,R2";
      3'd2, 3'd3: return "R1,R3";
      3'd6:       return "R1,R5";
      default:    return "R1,R4";
    endcase
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt >= 190000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc_cnt);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] e_r;
    logic [3:0] e_f;
    logic e_w;
    logic [2:0] e_c;
    op = 8'h00; opnd = 8'h00; fl_in = 4'h0;
    repeat (3) @(negedge clk);
    // reset-time vector: rotate-left of zero
    chk("R2 reset res", res, 0);
    chk("R6 reset flags", fl_out, 4'b1000);
    chk("R9 reset wr", wr_en, 1);
    chk("R10 reset cyc", mcyc, 2);
    rst_n = 1'b1;
    for (int o = 0; o < 256; o++) begin
      for (int v = 0; v < 256; v++) begin
        for (int c = 0; c < 2; c++) begin
          op = 8'(o);
          opnd = 8'(v);
          fl_in = {opnd[3] ^ op[0], opnd[5], opnd[6] ^ op[3], 1'(c)};
          @(negedge clk);
          model(op, opnd, fl_in, e_r, e_f, e_w, e_c);
          chk(res_tag(op), res, e_r);
          chk((op[7:6] == 2'd0) ? "R6" : (op[7:6] == 2'd1) ? "R7" : "R8", fl_out, e_f);
          chk("R9", wr_en, e_w);
          chk("R10", mcyc, e_c);
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule